// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two component predictors. The first is a global-history table of 3-bit counters, indexed by the branch word address XORed with the recent outcomes of all branches. The second is a two-level local predictor. Its first level holds one history register per group of branch addresses. Its second level is a table of 2-bit counters, indexed by the branch address XORed with that per-branch history. A chooser table of 2-bit counters, indexed by the branch address alone, decides which component supplies the final answer.

The predict side is combinational. The caller presents a branch word address (the PC with its 2 alignment bits already removed). In the same cycle the block returns the final direction, both component directions and the chooser decision. The caller keeps the two component directions and hands them back on the update port together with the resolved outcome. All tables and histories change on the clock edge of an update. Histories are not speculative: updates are expected in program order, with no other update between a branch's prediction and its own update.

Top module: `tournament_bp`

## Requirements
- R1: After reset every counter is weakly not-taken (global 3, local 1, chooser 1) and all histories are zero. Every address therefore predicts not-taken from both components and from the final output, with `pred_use_global` = 0.
- R2: The global table index is the low `G_BITS` of the word address XORed with the `G_BITS`-wide global history. A global counter predicts taken when its value is 4 or more.
- R3: Every counter saturates. A 3-bit counter stays within 0..7 and a 2-bit counter within 0..3. Repeated same-direction updates never wrap.
- R4: The local first level is indexed by the low `L1_BITS` of the word address and yields an `L_BITS` history. The second-level index is the low `L_BITS` of the address XORed with that history. A local counter predicts taken when its value is 2 or more.
- R5: The chooser is indexed by the low `S_BITS` of the word address. A value of 2 or more selects the global component. `pred_taken` equals the selected component's direction.
- R6: On update, the chooser entry changes only when the two returned component directions differ. It increments (saturating) when the global component was right and decrements when the local component was right.
- R7: On each update the global history shifts left by one with the outcome entering bit 0. Without an update it holds.
- R8: On update, only the local history entry addressed by the update address shifts, in the same way. In a cycle with no update, no prediction output changes for an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | PCW | Word address of the branch to predict |
| pred_taken | output | 1 | Final predicted direction |
| pred_glob_taken | output | 1 | Global component direction |
| pred_loc_taken | output | 1 | Local component direction |
| pred_use_global | output | 1 | Chooser selects the global component |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_pc | input | PCW | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_glob_taken | input | 1 | Global component direction returned from prediction |
| upd_loc_taken | input | 1 | Local component direction returned from prediction |

## Verification
A sweep with no updates after reset separates correct reset values from counters that start on the wrong side of the threshold. A branch that is always taken and then briefly not taken shows whether counters saturate or wrap. A repeating taken-taken-taken-not loop exposes local-history indexing, because only a correct per-branch history predicts the exit. An alternating branch and a long pseudo-random interleaving of aliasing addresses exercise the XOR hashes and chooser migration. Quiet sweeps between phases show that only updates change state.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int GCTR_W = 3;
  localparam int LCTR_W = 2;
  localparam int SCTR_W = 2;
  localparam logic [GCTR_W-1:0] GCTR_INIT = 3'd3;
  localparam logic [LCTR_W-1:0] LCTR_INIT = 2'd1;
  localparam logic [SCTR_W-1:0] SCTR_INIT = 2'd1;
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2,
  parameter logic [CTR_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_d [DEPTH];
  logic [CTR_W-1:0] cur;

  assign cur      = ctr_q[wr_idx];
  assign rd_taken = ctr_q[rd_idx][CTR_W-1];

  always_comb begin
    ctr_d = ctr_q;
    if (wr_en) begin
      if (wr_up && cur != CMAX)
        ctr_d[wr_idx] = cur + 1'b1;
      else if (!wr_up && cur != '0)
        ctr_d[wr_idx] = cur - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT;
    end else if (wr_en) begin
      ctr_q <= ctr_d;
    end
  end
endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W = 4,
  parameter int H_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic [IDX_W-1:0] up_idx,
  output logic [H_W-1:0]   up_hist,
  input  logic             wr_en,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [H_W-1:0] hist_q [DEPTH];
  logic [H_W-1:0] hist_d [DEPTH];

  assign rd_hist = hist_q[rd_idx];
  assign up_hist = hist_q[up_idx];

  always_comb begin
    hist_d = hist_q;
    if (wr_en) hist_d[up_idx] = {up_hist[H_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int G_BITS  = 6,
  parameter int L1_BITS = 4,
  parameter int L_BITS  = 6,
  parameter int S_BITS  = 6,
  localparam int M1  = (G_BITS > L_BITS) ? G_BITS : L_BITS,
  localparam int M2  = (L1_BITS > S_BITS) ? L1_BITS : S_BITS,
  localparam int PCW = (M1 > M2) ? M1 : M2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PCW-1:0] pred_pc,
  output logic           pred_taken,
  output logic           pred_glob_taken,
  output logic           pred_loc_taken,
  output logic           pred_use_global,
  input  logic           upd_valid,
  input  logic [PCW-1:0] upd_pc,
  input  logic           upd_taken,
  input  logic           upd_glob_taken,
  input  logic           upd_loc_taken
);
  import tbp_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // global history
  logic [G_BITS-1:0] ghist_q, ghist_d;
  always_comb begin
    ghist_d = ghist_q;
    if (upd_valid) ghist_d = {ghist_q[G_BITS-2:0], upd_taken};
  end
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)       ghist_q <= '0;
    else if (upd_valid) ghist_q <= ghist_d;
  end

  // index hashing
  logic [G_BITS-1:0]  g_idx_p, g_idx_u;
  logic [L_BITS-1:0]  lh_p, lh_u, l_idx_p, l_idx_u;
  assign g_idx_p = pred_pc[G_BITS-1:0] ^ ghist_q;
  assign g_idx_u = upd_pc[G_BITS-1:0]  ^ ghist_q;
  assign l_idx_p = pred_pc[L_BITS-1:0] ^ lh_p;
  assign l_idx_u = upd_pc[L_BITS-1:0]  ^ lh_u;

  tbp_hist_table #(.IDX_W(L1_BITS), .H_W(L_BITS)) u_lhist (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(pred_pc[L1_BITS-1:0]), .rd_hist(lh_p),
    .up_idx(upd_pc[L1_BITS-1:0]),  .up_hist(lh_u),
    .wr_en(upd_valid), .wr_bit(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(G_BITS), .CTR_W(GCTR_W), .INIT(GCTR_INIT)) u_gtab (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(g_idx_p), .rd_taken(pred_glob_taken),
    .wr_en(upd_valid), .wr_idx(g_idx_u), .wr_up(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(L_BITS), .CTR_W(LCTR_W), .INIT(LCTR_INIT)) u_ltab (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(l_idx_p), .rd_taken(pred_loc_taken),
    .wr_en(upd_valid), .wr_idx(l_idx_u), .wr_up(upd_taken)
  );

  logic sel_wr;
  assign sel_wr = upd_valid && (upd_glob_taken != upd_loc_taken);

  tbp_ctr_table #(.IDX_W(S_BITS), .CTR_W(SCTR_W), .INIT(SCTR_INIT)) u_sel (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(pred_pc[S_BITS-1:0]), .rd_taken(pred_use_global),
    .wr_en(sel_wr), .wr_idx(upd_pc[S_BITS-1:0]),
    .wr_up(upd_glob_taken == upd_taken)
  );

  assign pred_taken = pred_use_global ? pred_glob_taken : pred_loc_taken;
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
  parameter int G_BITS = 6,
  parameter int PCW    = 6
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [PCW-1:0]    pred_pc,
  input logic              pred_glob_taken,
  input logic              pred_loc_taken,
  input logic              pred_use_global,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              upd_glob_taken,
  input logic              upd_loc_taken,
  input logic [G_BITS-1:0] ghist_q
);
  p_ghist_shift_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_valid |=> ghist_q == {$past(ghist_q[G_BITS-2:0]), $past(upd_taken)});

  p_ghist_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !upd_valid |=> $stable(ghist_q));

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!upd_valid ##1 $stable(pred_pc)) |->
      ($stable(pred_taken) && $stable(pred_glob_taken) &&
       $stable(pred_loc_taken) && $stable(pred_use_global)));

  p_sel_agree_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((upd_valid && upd_glob_taken == upd_loc_taken) ##1 $stable(pred_pc))
      |-> $stable(pred_use_global));

  p_sel_toward_glob_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((upd_valid && upd_glob_taken != upd_loc_taken &&
      upd_glob_taken == upd_taken && pred_use_global) ##1 $stable(pred_pc))
      |-> pred_use_global);

  p_sel_toward_loc_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((upd_valid && upd_glob_taken != upd_loc_taken &&
      upd_loc_taken == upd_taken && !pred_use_global) ##1 $stable(pred_pc))
      |-> !pred_use_global);
endmodule

bind tournament_bp tournament_bp_chk #(.G_BITS(G_BITS), .PCW(PCW)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .pred_pc(pred_pc),
  .pred_glob_taken(pred_glob_taken), .pred_loc_taken(pred_loc_taken),
  .pred_use_global(pred_use_global), .pred_taken(pred_taken),
  .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_glob_taken(upd_glob_taken), .upd_loc_taken(upd_loc_taken),
  .ghist_q(ghist_q)
);

// File: tb/tb_tournament_bp.sv
module tb_tournament_bp;
  localparam int GB = 6, L1B = 4, LB = 6, SB = 6, PCW = 6;
  localparam int GM = (1 << GB) - 1, LM = (1 << LB) - 1;
  localparam int L1M = (1 << L1B) - 1, SM = (1 << SB) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PCW-1:0] pred_pc = '0;
  logic pred_taken, pred_glob_taken, pred_loc_taken, pred_use_global;
  logic upd_valid = 1'b0;
  logic [PCW-1:0] upd_pc = '0;
  logic upd_taken = 1'b0, upd_glob_taken = 1'b0, upd_loc_taken = 1'b0;

  always #4 clk = ~clk;

  tournament_bp dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_glob_taken(pred_glob_taken), .pred_loc_taken(pred_loc_taken),
    .pred_use_global(pred_use_global), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_glob_taken(upd_glob_taken),
    .upd_loc_taken(upd_loc_taken)
  );

  typedef struct {
    int pc; bit t; bit g; bit l; bit s; string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;

  // independent reference model built from the requirements
  int gm[64], lm[64], sm[64], lh[16];
  int gh;

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin gm[i] = 3; lm[i] = 1; sm[i] = 1; end
    for (int i = 0; i < 16; i++) lh[i] = 0;
    gh = 0;
  endtask

  task automatic model_pred(input int pc, output exp_t e);
    e.pc = pc;
    e.g  = gm[(pc ^ gh) & GM] >= 4;                 // R2
    e.l  = lm[(pc ^ lh[pc & L1M]) & LM] >= 2;       // R4
    e.s  = sm[pc & SM] >= 2;                        // R5
    e.t  = e.s ? e.g : e.l;
  endtask

  task automatic model_upd(input int pc, input bit t, input bit g, input bit l);
    int gi, li, h;
    gi = (pc ^ gh) & GM;
    h  = lh[pc & L1M];
    li = (pc ^ h) & LM;
    if (t) begin if (gm[gi] < 7) gm[gi]++; if (lm[li] < 3) lm[li]++; end  // R3
    else   begin if (gm[gi] > 0) gm[gi]--; if (lm[li] > 0) lm[li]--; end
    if (g != l) begin                                                    // R6
      if (g == t) begin if (sm[pc & SM] < 3) sm[pc & SM]++; end
      else        begin if (sm[pc & SM] > 0) sm[pc & SM]--; end
    end
    gh = ((gh << 1) | t) & GM;                                           // R7
    lh[pc & L1M] = ((h << 1) | t) & LM;                                  // R8
  endtask

  task automatic chk(input bit act, input bit exp, input string what, input int pc);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%0d actual=%0b expected=%0b", what, pc, act, exp);
    end
  endtask

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(pred_glob_taken, e.g, {e.tag, " R2 global"}, e.pc);
      chk(pred_loc_taken,  e.l, {e.tag, " R4 local"},  e.pc);
      chk(pred_use_global, e.s, {e.tag, " R5 chooser"}, e.pc);
      chk(pred_taken,      e.t, {e.tag, " R5 final"},   e.pc);
    end
  end

  // driver: predict, push expectation, optionally update in the same cycle
  task automatic branch(input int pc, input bit do_upd, input bit t, input string tag);
    exp_t e;
    @(negedge clk);
    model_pred(pc, e);
    e.tag = tag;
    q.push_back(e);
    pred_pc        = pc[PCW-1:0];
    upd_valid      = do_upd;
    upd_pc         = pc[PCW-1:0];
    upd_taken      = t;
    upd_glob_taken = e.g;
    upd_loc_taken  = e.l;
    @(posedge clk);
    if (do_upd) model_upd(pc, t, e.g, e.l);
    #1 upd_valid = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 64; p++) branch(p, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    bit t;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    sweep("R1 reset");                                    // R1 and R8 quiet
    for (int i = 0; i < 12; i++) branch(5, 1'b1, 1'b1, "R3 sat-up");
    for (int i = 0; i < 3; i++)  branch(5, 1'b1, 1'b0, "R3 dip");
    for (int i = 0; i < 4; i++)  branch(5, 1'b1, 1'b1, "R3 recover");
    for (int i = 0; i < 10; i++) branch(17, 1'b1, 1'b0, "R3 sat-down");
    for (int i = 0; i < 160; i++) branch(9, 1'b1, (i % 4) != 3, "R4 loop");
    for (int i = 0; i < 60; i++) branch(12, 1'b1, i[0], "R6 alternate");
    sweep("R8 quiet");
    lfsr = 32'h1d;
    for (int i = 0; i < 1500; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB8 : 0);
      t = ((lfsr & 3) != 0) ^ (lfsr[5] & lfsr[6]);
      branch(lfsr & 63, 1'b1, t, "R7 mixed");
    end
    sweep("R8 final");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule